// File: doc/BRIEF.md
# Chained serial-load register with held parallel outputs

The block takes a serial bit stream on one pin and moves it through a chain of shift stages on the rising edge of a shift clock. A second, independent rising-edge clock copies every shift stage at once into a storage register, and the storage register drives the parallel outputs. The parallel bus therefore changes only when the register clock fires, no matter how much shifting happens in between. The shift stages are built as 8-bit sections. The number of sections is a parameter, and the last stage of each section feeds the first stage of the next. A word of SECTIONS×8 bits is loaded with that many shift pulses followed by one register-clock pulse.

An active-low asynchronous clear empties the shift stages only. The held outputs keep their value until the next register-clock edge. An active-low output enable either drives the parallel bus or releases it to high impedance. The serial output always shows the final shift stage so that further devices can be chained behind it, and the output enable has no effect on it. The pins are plain control and data pins with no handshake: every bit is accepted on a clock edge, and nothing at the edge of the block can stall.

Top module: `serial_latch_shifter`

## Requirements
- R1: On each rising edge of `shift_clk` while `clear_n` is high, stage 0 takes `ser_in` and each stage k>0 takes the old value of stage k-1. `ser_out` always equals the last stage, index SECTIONS*8-1.
- R2: On each rising edge of `load_clk`, all stages are copied together into the storage register. While enabled, `par_q[k]` shows the stored copy of stage k.
- R3: While `clear_n` is low, every shift stage is 0 at once, without waiting for a clock edge. This holds even if `shift_clk` pulses during the clear, so `ser_out` reads 0 and a `load_clk` edge in this state stores all zeros.
- R4: Asserting and releasing `clear_n` leaves `par_q` unchanged until the next `load_clk` edge.
- R5: With `out_en_n` high, every bit of `par_q` is high impedance and the stored value is kept. When `out_en_n` returns low, the stored value is driven again.
- R6: `ser_out` is driven and follows the last stage whatever the level of `out_en_n`.
- R7: When `shift_clk` and `load_clk` rise together, the storage register captures the stage contents from before that edge, one pulse behind the shift stages.
- R8: Sections are chained in order. After SECTIONS*8 shift pulses and one load pulse, the first bit shifted in appears on `par_q[SECTIONS*8-1]` and the last bit shifted in appears on `par_q[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Rising edge advances the shift stages |
| load_clk | input | 1 | Rising edge copies the shift stages into storage |
| clear_n | input | 1 | Asynchronous clear of the shift stages, active low |
| out_en_n | input | 1 | Parallel output enable, active low; high releases `par_q` |
| ser_in | input | 1 | Serial data into stage 0 |
| par_q | output | SECTIONS*8 | Stored word, high impedance when disabled |
| ser_out | output | 1 | Last shift stage, for chaining further devices |

## Verification
The hardest condition to reach from the ports is high impedance on the parallel bus. A two-state view cannot tell a released bus from a driven zero. The bench therefore places its own driver on the same net while the enable is off and drives all-zeros and then all-ones. Both patterns must read back unchanged, which can only happen if the block has let go of every bit. A stored word with ones and zeros mixed in is latched beforehand, so a block that keeps driving would disturb at least one of the two readings. The clear-during-shift case is reached by pulsing the shift clock while the clear is held low. The result is then loaded and read back.

// File: rtl/serial_latch_pkg.sv
package serial_latch_pkg;
  parameter int SECT_BITS = 8;
endpackage

// File: rtl/shift_section.sv
module shift_section
  import serial_latch_pkg::*;
(
  input  logic                 shift_clk,
  input  logic                 clear_n,
  input  logic                 din,
  output logic [SECT_BITS-1:0] stages,
  output logic                 dout
);
  always_ff @(posedge shift_clk or negedge clear_n) begin
    if (!clear_n) stages <= '0;
    else          stages <= {stages[SECT_BITS-2:0], din};
  end

  assign dout = stages[SECT_BITS-1];
endmodule

// File: rtl/hold_register.sv
module hold_register #(
  parameter int WIDTH = 16
) (
  input  logic             load_clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // No reset: the value is defined by the first load edge.
  always_ff @(posedge load_clk) q <= d;
endmodule

// File: rtl/tristate_bus.sv
module tristate_bus #(
  parameter int WIDTH = 16
) (
  input  logic             en_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] pad
);
  assign pad = en_n ? {WIDTH{1'bz}} : d;
endmodule

// File: rtl/serial_latch_shifter.sv
module serial_latch_shifter
  import serial_latch_pkg::*;
#(
  parameter int SECTIONS = 2,
  localparam int TOTAL = SECTIONS * SECT_BITS
) (
  input  logic             shift_clk,
  input  logic             load_clk,
  input  logic             clear_n,
  input  logic             out_en_n,
  input  logic             ser_in,
  output logic [TOTAL-1:0] par_q,
  output logic             ser_out
);
  logic [SECTIONS:0] link;
  logic [TOTAL-1:0]  shift_q;
  logic [TOTAL-1:0]  stor_q;

  assign link[0] = ser_in;

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sect
    shift_section u_sect (
      .shift_clk (shift_clk),
      .clear_n   (clear_n),
      .din       (link[s]),
      .stages    (shift_q[s*SECT_BITS +: SECT_BITS]),
      .dout      (link[s+1])
    );
  end

  assign ser_out = link[SECTIONS];

  hold_register #(.WIDTH(TOTAL)) u_hold (
    .load_clk (load_clk),
    .d        (shift_q),
    .q        (stor_q)
  );

  tristate_bus #(.WIDTH(TOTAL)) u_bus (
    .en_n (out_en_n),
    .d    (stor_q),
    .pad  (par_q)
  );
endmodule

// File: rtl/serial_latch_chk.sv
module serial_latch_chk #(
  parameter int TOTAL = 16
) (
  input logic             shift_clk,
  input logic             load_clk,
  input logic             clear_n,
  input logic             ser_in,
  input logic             ser_out,
  input logic [TOTAL-1:0] shift_q,
  input logic [TOTAL-1:0] stor_q
);
  // Goes high on any clear and drops at the next shift edge, so a clear
  // pulsed between two shift edges is visible at the second one.
  logic clr_hit;
  always_ff @(posedge shift_clk or negedge clear_n) begin
    if (!clear_n) clr_hit <= 1'b1;
    else          clr_hit <= 1'b0;
  end

  a_r1_shift_step: assert property (@(posedge shift_clk) disable iff (!clear_n)
    1'b1 |=> (clr_hit || (shift_q == {$past(shift_q[TOTAL-2:0]), $past(ser_in)})));

  a_r2_load_copy: assert property (@(posedge load_clk) disable iff (!clear_n)
    1'b1 |=> (stor_q == $past(shift_q)));

  a_r3_clear_serial_zero: assert property (@(posedge load_clk) disable iff (1'b0)
    !clear_n |-> (ser_out == 1'b0));

  a_r3_clear_load_zero: assert property (@(posedge load_clk) disable iff (1'b0)
    !clear_n |=> (stor_q == '0));
endmodule

bind serial_latch_shifter serial_latch_chk #(.TOTAL(TOTAL)) u_chk (
  .shift_clk (shift_clk),
  .load_clk  (load_clk),
  .clear_n   (clear_n),
  .ser_in    (ser_in),
  .ser_out   (ser_out),
  .shift_q   (shift_q),
  .stor_q    (stor_q)
);

// File: tb/tb_serial_latch_shifter.sv
module tb_serial_latch_shifter;
  localparam int SECTIONS = 2;
  localparam int M = SECTIONS * 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic shift_clk = 1'b0, load_clk = 1'b0, clear_n = 1'b0, out_en_n = 1'b0, ser_in = 1'b0;
  logic ser_out;
  wire  [M-1:0] q_bus;
  logic tb_drv = 1'b0;
  logic [M-1:0] tb_val = '0;
  assign q_bus = tb_drv ? tb_val : {M{1'bz}};

  serial_latch_shifter #(.SECTIONS(SECTIONS)) dut (
    .shift_clk (shift_clk),
    .load_clk  (load_clk),
    .clear_n   (clear_n),
    .out_en_n  (out_en_n),
    .ser_in    (ser_in),
    .par_q     (q_bus),
    .ser_out   (ser_out)
  );

  int n_chk = 0, n_bad = 0;
  logic [M-1:0] m_shift = '0, m_stor = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_shift(input logic b);
    @(negedge clk) ser_in = b;
    #1 shift_clk = 1'b1;
    @(negedge clk) shift_clk = 1'b0;
    if (clear_n) m_shift = {m_shift[M-2:0], b};
    #1;
  endtask

  task automatic do_load();
    @(negedge clk) #1 load_clk = 1'b1;
    @(negedge clk) load_clk = 1'b0;
    m_stor = m_shift;
    #1;
  endtask

  task automatic do_both(input logic b);
    @(negedge clk) ser_in = b;
    #1 begin shift_clk = 1'b1; load_clk = 1'b1; end
    @(negedge clk) begin shift_clk = 1'b0; load_clk = 1'b0; end
    m_stor = m_shift;
    m_shift = {m_shift[M-2:0], b};
    #1;
  endtask

  task automatic load_word(input logic [M-1:0] w);
    for (int i = M-1; i >= 0; i--) begin
      do_shift(w[i]);
      chk(ser_out === m_shift[M-1], "R1 ser_out", {{(M-1){1'b0}}, ser_out}, {{(M-1){1'b0}}, m_shift[M-1]});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(ser_out === 1'b0, "R3 clear at reset", {{(M-1){1'b0}}, ser_out}, '0);
    @(negedge clk) clear_n = 1'b1;
    do_load();
    chk(q_bus === '0, "R3 load after clear", q_bus, '0);

    // R8/R2 sweep: bit order of a full chained word
    for (int v = 0; v < 256; v++) begin
      logic [M-1:0] w;
      w = {v[7:0], v[7:0] ^ 8'h5A};
      load_word(w);
      chk(m_shift === w, "R8 model", m_shift, w);
      do_load();
      chk(q_bus === w, "R8 R2 word", q_bus, w);
    end

    // R4: clear leaves outputs alone; R3: clear zeros stages, also with shifting
    load_word(16'hC3A5);
    do_load();
    load_word(16'h0FF0);
    @(negedge clk) clear_n = 1'b0;
    m_shift = '0;
    #1 chk(ser_out === 1'b0, "R3 async clear", {{(M-1){1'b0}}, ser_out}, '0);
    chk(q_bus === 16'hC3A5, "R4 held during clear", q_bus, 16'hC3A5);
    do_shift(1'b1);
    do_shift(1'b1);
    chk(ser_out === 1'b0, "R3 shift ignored", {{(M-1){1'b0}}, ser_out}, '0);
    @(negedge clk) clear_n = 1'b1;
    #1 chk(q_bus === 16'hC3A5, "R4 held after clear", q_bus, 16'hC3A5);
    do_load();
    chk(q_bus === '0, "R3 cleared stages loaded", q_bus, '0);

    // R5/R6: high impedance, serial path unaffected
    load_word(16'h96E1);
    do_load();
    load_word(16'h8000);
    @(negedge clk) out_en_n = 1'b1;
    #1 begin tb_val = '0; tb_drv = 1'b1; end
    #1 chk(q_bus === '0, "R5 hiz low probe", q_bus, '0);
    tb_val = '1;
    #1 chk(q_bus === '1, "R5 hiz high probe", q_bus, '1);
    chk(ser_out === 1'b1, "R6 ser_out while disabled", {{(M-1){1'b0}}, ser_out}, 16'h1);
    do_shift(1'b0);
    chk(ser_out === 1'b0, "R6 ser_out shifts while disabled", {{(M-1){1'b0}}, ser_out}, '0);
    tb_drv = 1'b0;
    @(negedge clk) out_en_n = 1'b0;
    #1 chk(q_bus === 16'h96E1, "R5 stored value returns", q_bus, 16'h96E1);

    // R7: tied clocks lag by one pulse
    for (int i = 0; i < 40; i++) begin
      do_both(((i * 7) % 5) < 2);
      chk(q_bus === m_stor, "R7 tied clocks lag", q_bus, m_stor);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule